// File: doc/BRIEF.md
# Packed-Lane Integer Media ALU

This unit splits two 64-bit source words into equal lanes (eight bytes, four halfwords or two words) and applies one arithmetic operation to every lane pair at once. It covers wrapping and clamping add and subtract, equality and greater-than masks, averaging, minimum and maximum, a byte sum of absolute differences, and a halfword multiply whose product is shifted right before truncation. One operation is accepted per cycle. The result, a valid flag and an illegal flag appear one cycle later.

Each operation accepts only some lane sizes. The multiply-shift also accepts only four shift counts. Any other combination is rejected: the illegal flag goes high and the result is forced to zero.

Top module: `simd_int_alu`

## Requirements
- R1: After reset, valid_o, result_o and illegal_o are all zero. valid_o is valid_i delayed by one clock. result_o and illegal_o update only for cycles with valid_i high, and hold their values otherwise.
- R2: Lane size codes are 0 for bytes, 1 for halfwords and 2 for words. op_i 0 (add) and 1 (sub) wrap modulo the lane width, for all three sizes.
- R3: op_i 2 (add) and 3 (sub) clamp the result to the lane range, for byte and halfword lanes only. The range is signed when signed_i=1 and unsigned when signed_i=0.
- R4: op_i 4 (equal) and 5 (greater-than) write all-ones to a lane when the relation holds and all-zeros when it does not, for all three sizes. Greater-than compares signed values when signed_i=1 and unsigned values otherwise.
- R5: op_i 6 gives the unsigned lane average, for byte and halfword lanes. With round_i=0 it is floor((a+b)/2). With round_i=1 it is (a+b+1)>>1, which rounds halves up.
- R6: op_i 7 gives the lane minimum and op_i 8 the lane maximum, for byte and halfword lanes. They compare signed values when signed_i=1 and unsigned values otherwise.
- R7: op_i 9, on byte lanes only, adds the eight unsigned absolute byte differences and returns the sum zero-extended to 64 bits.
- R8: op_i 10, on halfword lanes only, forms the full product of each lane pair. The operands are signed when signed_i=1 and unsigned otherwise. The product is shifted right by shift_i, arithmetically when signed, and the low 16 bits are kept. shift_i must be 0, 7, 15 or 16.
- R9: These combinations raise illegal_o and give result_o = 0:
  - size code 3;
  - op_i 11 to 15;
  - an operation given a lane size it does not accept;
  - op_i 10 with any other shift count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request this cycle |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Lane size code |
| signed_i | input | 1 | Signed interpretation select |
| round_i | input | 1 | Average round-up select |
| shift_i | input | 5 | Multiply-shift right count |
| src_a_i | input | 64 | First source word |
| src_b_i | input | 64 | Second source word |
| valid_o | output | 1 | Result valid, one cycle after request |
| result_o | output | 64 | Lane-wise result |
| illegal_o | output | 1 | Rejected operation, size or shift |

## Verification
The bound checker checks these on every cycle:
- valid_o follows valid_i delayed by one cycle;
- a rejected request always returns a zero word;
- size code 3 and bad multiply-shift counts are always flagged;
- a byte-difference sum never sets bits above its 11-bit range;
- every byte of an equality mask is either 00 or FF.

The exact lane values can only be shown by the bench's vectors. These include clamping at both signed limits and the unsigned limits, the two average roundings, and the arithmetic shift of a negative product. The hold of the outputs while valid_i is low is also checked by the bench.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDS = 4'd2,
    OP_SUBS = 4'd3,
    OP_CEQ  = 4'd4,
    OP_CGT  = 4'd5,
    OP_AVG  = 4'd6,
    OP_MIN  = 4'd7,
    OP_MAX  = 4'd8,
    OP_SAD  = 4'd9,
    OP_MSR  = 4'd10
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2
  } sz_e;

  function automatic logic shift_ok(input logic [4:0] sh);
    return (sh == 5'd0) || (sh == 5'd7) || (sh == 5'd15) || (sh == 5'd16);
  endfunction

  // legal operation / lane size / shift combinations
  function automatic logic pair_legal(input logic [3:0] op, input logic [1:0] sz,
                                      input logic [4:0] sh);
    logic ok;
    case (op)
      OP_ADD, OP_SUB, OP_CEQ, OP_CGT:          ok = (sz <= SZ_W);
      OP_ADDS, OP_SUBS, OP_AVG, OP_MIN, OP_MAX: ok = (sz <= SZ_H);
      OP_SAD:                                  ok = (sz == SZ_B);
      OP_MSR:                                  ok = (sz == SZ_H) && shift_ok(sh);
      default:                                 ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op_i,
  input  logic         signed_i,
  input  logic         round_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] UMAX = {W{1'b1}};

  logic [W:0]        sum_u, dif_u, avg_t;
  logic signed [W:0] sum_s, dif_s;
  logic              a_gt;
  logic [W-1:0]      sat_add, sat_sub;

  always_comb begin
    sum_u = {1'b0, a_i} + {1'b0, b_i};
    dif_u = {1'b0, a_i} - {1'b0, b_i};
    sum_s = $signed({a_i[W-1], a_i}) + $signed({b_i[W-1], b_i});
    dif_s = $signed({a_i[W-1], a_i}) - $signed({b_i[W-1], b_i});
    avg_t = sum_u + {{W{1'b0}}, round_i};
    a_gt  = signed_i ? ($signed(a_i) > $signed(b_i)) : (a_i > b_i);

    if (signed_i) begin
      if (sum_s[W] != sum_s[W-1]) sat_add = sum_s[W] ? SMIN : SMAX;
      else                        sat_add = sum_s[W-1:0];
      if (dif_s[W] != dif_s[W-1]) sat_sub = dif_s[W] ? SMIN : SMAX;
      else                        sat_sub = dif_s[W-1:0];
    end else begin
      sat_add = sum_u[W] ? UMAX : sum_u[W-1:0];
      sat_sub = dif_u[W] ? '0 : dif_u[W-1:0];
    end

    case (op_i)
      OP_ADD:  res_o = sum_u[W-1:0];
      OP_SUB:  res_o = dif_u[W-1:0];
      OP_ADDS: res_o = sat_add;
      OP_SUBS: res_o = sat_sub;
      OP_CEQ:  res_o = (a_i == b_i) ? UMAX : '0;
      OP_CGT:  res_o = a_gt ? UMAX : '0;
      OP_AVG:  res_o = avg_t[W:1];
      OP_MIN:  res_o = a_gt ? b_i : a_i;
      OP_MAX:  res_o = a_gt ? a_i : b_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/simd_sad.sv
module simd_sad #(
  parameter int LANES = 8,
  parameter int W     = 8,
  localparam int SUM_W = W + $clog2(LANES)
) (
  input  logic [LANES*W-1:0] a_i,
  input  logic [LANES*W-1:0] b_i,
  output logic [SUM_W-1:0]   sum_o
);

  always_comb begin
    sum_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (a_i[l*W +: W] >= b_i[l*W +: W])
        sum_o = sum_o + SUM_W'(a_i[l*W +: W] - b_i[l*W +: W]);
      else
        sum_o = sum_o + SUM_W'(b_i[l*W +: W] - a_i[l*W +: W]);
    end
  end

endmodule

// File: rtl/simd_mulshr.sv
module simd_mulshr #(
  parameter int LANES = 4,
  parameter int W     = 16,
  parameter int SH_W  = 5
) (
  input  logic               signed_i,
  input  logic [SH_W-1:0]    shift_i,
  input  logic [LANES*W-1:0] a_i,
  input  logic [LANES*W-1:0] b_i,
  output logic [LANES*W-1:0] res_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [W:0]     ea, eb;
    logic signed [2*W+1:0] prod, shd_unused;

    always_comb begin
      ea = signed_i ? {a_i[l*W+W-1], a_i[l*W +: W]} : {1'b0, a_i[l*W +: W]};
      eb = signed_i ? {b_i[l*W+W-1], b_i[l*W +: W]} : {1'b0, b_i[l*W +: W]};
      prod = ea * eb;
      // zero-extended operands keep the sign bit clear, so >>> is logical then
      shd_unused = prod >>> shift_i;
    end

    assign res_o[l*W +: W] = shd_unused[W-1:0];
  end

endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic              round_i,
  input  logic [4:0]        shift_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);

  localparam int N_SZ    = 3;
  localparam int B_LANES = DATA_W / 8;
  localparam int H_LANES = DATA_W / 16;
  localparam int SAD_W   = 8 + $clog2(B_LANES);

  logic [DATA_W-1:0] lane_res [N_SZ];
  logic [SAD_W-1:0]  sad_sum;
  logic [DATA_W-1:0] msr_res;
  logic [DATA_W-1:0] sel_res;
  logic              legal;

  for (genvar s = 0; s < N_SZ; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int LN = DATA_W / LW;
    logic [DATA_W-1:0] res_v;

    for (genvar l = 0; l < LN; l++) begin : g_lane
      simd_lane #(.W(LW)) u_lane (
        .op_i    (op_i),
        .signed_i(signed_i),
        .round_i (round_i),
        .a_i     (src_a_i[l*LW +: LW]),
        .b_i     (src_b_i[l*LW +: LW]),
        .res_o   (res_v[l*LW +: LW])
      );
    end

    assign lane_res[s] = res_v;
  end

  simd_sad #(.LANES(B_LANES), .W(8)) u_sad (
    .a_i  (src_a_i),
    .b_i  (src_b_i),
    .sum_o(sad_sum)
  );

  simd_mulshr #(.LANES(H_LANES), .W(16), .SH_W(5)) u_msr (
    .signed_i(signed_i),
    .shift_i (shift_i),
    .a_i     (src_a_i),
    .b_i     (src_b_i),
    .res_o   (msr_res)
  );

  always_comb begin
    legal = pair_legal(op_i, size_i, shift_i);
    if (!legal)               sel_res = '0;
    else if (op_i == OP_SAD)  sel_res = {{(DATA_W-SAD_W){1'b0}}, sad_sum};
    else if (op_i == OP_MSR)  sel_res = msr_res;
    else                      sel_res = lane_res[size_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      result_o  <= '0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o  <= sel_res;
        illegal_o <= !legal;
      end
    end
  end

endmodule

// File: rtl/simd_int_alu_chk.sv
module simd_int_alu_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic [1:0]        size_i,
  input logic [4:0]        shift_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);

  logic       prev_valid;
  logic [3:0] prev_op;
  logic [1:0] prev_size;
  logic [4:0] prev_shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_valid <= 1'b0;
      prev_op    <= '0;
      prev_size  <= '0;
      prev_shift <= '0;
    end else begin
      prev_valid <= valid_i;
      if (valid_i) begin
        prev_op    <= op_i;
        prev_size  <= size_i;
        prev_shift <= shift_i;
      end
    end
  end

  function automatic logic bytes_are_masks(input logic [DATA_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DATA_W/8; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  a_r1_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == prev_valid);

  a_r9_zero_on_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && illegal_o) |-> (result_o == '0));

  a_r9_bad_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && prev_size == 2'd3) |-> illegal_o);

  a_r8_bad_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && prev_op == 4'd10 &&
     !(prev_shift == 5'd0 || prev_shift == 5'd7 || prev_shift == 5'd15 || prev_shift == 5'd16))
    |-> illegal_o);

  a_r7_sad_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o && prev_op == 4'd9) |-> (result_o[DATA_W-1:11] == '0));

  a_r4_eq_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !illegal_o && prev_op == 4'd4) |-> bytes_are_masks(result_o));

endmodule

bind simd_int_alu simd_int_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .size_i   (size_i),
  .shift_i  (shift_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .illegal_o(illegal_o)
);

// File: tb/simd_int_alu_tb.sv
module simd_int_alu_tb;

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sz;
    logic        sg;
    logic        rn;
    logic [4:0]  sh;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] exp;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    // R2 wrap
    '{4'd0, 2'd0, 1'b0, 1'b0, 5'd0, 64'h01020304050607FF, 64'h0101010101010101, 64'h0203040506070800, 1'b0, 8'd2},
    '{4'd0, 2'd1, 1'b0, 1'b0, 5'd0, 64'hFFFF00017FFF1234, 64'h0001000100010001, 64'h0000000280001235, 1'b0, 8'd2},
    '{4'd0, 2'd2, 1'b0, 1'b0, 5'd0, 64'hFFFFFFFF00000010, 64'h0000000100000020, 64'h0000000000000030, 1'b0, 8'd2},
    '{4'd1, 2'd0, 1'b0, 1'b0, 5'd0, 64'h0000000000000000, 64'h0101010101010101, 64'hFFFFFFFFFFFFFFFF, 1'b0, 8'd2},
    // R3 clamp
    '{4'd2, 2'd0, 1'b1, 1'b0, 5'd0, 64'h7F8010F000000000, 64'h01FF10F000000000, 64'h7F8020E000000000, 1'b0, 8'd3},
    '{4'd2, 2'd1, 1'b0, 1'b0, 5'd0, 64'hFFFF800000010000, 64'h0001800000010000, 64'hFFFFFFFF00020000, 1'b0, 8'd3},
    '{4'd3, 2'd0, 1'b0, 1'b0, 5'd0, 64'h0510000000000000, 64'h0601000000000000, 64'h000F000000000000, 1'b0, 8'd3},
    '{4'd3, 2'd1, 1'b1, 1'b0, 5'd0, 64'h80007FFF00000005, 64'h0001FFFF00010003, 64'h80007FFFFFFF0002, 1'b0, 8'd3},
    // R4 masks
    '{4'd4, 2'd2, 1'b0, 1'b0, 5'd0, 64'h1234567800000001, 64'h1234567800000002, 64'hFFFFFFFF00000000, 1'b0, 8'd4},
    '{4'd5, 2'd0, 1'b1, 1'b0, 5'd0, 64'h01807F0000000000, 64'h007F800000000000, 64'hFF00FF0000000000, 1'b0, 8'd4},
    '{4'd5, 2'd0, 1'b0, 1'b0, 5'd0, 64'h01807F0000000000, 64'h007F800000000000, 64'hFFFF000000000000, 1'b0, 8'd4},
    // R5 average
    '{4'd6, 2'd0, 1'b0, 1'b0, 5'd0, 64'h01FF020000000000, 64'h02FF030000000000, 64'h01FF020000000000, 1'b0, 8'd5},
    '{4'd6, 2'd0, 1'b0, 1'b1, 5'd0, 64'h01FF020000000000, 64'h02FF030000000000, 64'h02FF030000000000, 1'b0, 8'd5},
    // R6 min/max
    '{4'd7, 2'd1, 1'b1, 1'b0, 5'd0, 64'h80000005FFFF0000, 64'h7FFF000300010000, 64'h80000003FFFF0000, 1'b0, 8'd6},
    '{4'd8, 2'd1, 1'b0, 1'b0, 5'd0, 64'h80000005FFFF0000, 64'h7FFF000300010000, 64'h80000005FFFF0000, 1'b0, 8'd6},
    // R7 byte difference sum
    '{4'd9, 2'd0, 1'b0, 1'b0, 5'd0, 64'hFF00000000000005, 64'h00FF000000000008, 64'h0000000000000201, 1'b0, 8'd7},
    // R8 multiply-shift
    '{4'd10, 2'd1, 1'b0, 1'b0, 5'd0,  64'h0003FFFF01000000, 64'h0004000201000000, 64'h000CFFFE00000000, 1'b0, 8'd8},
    '{4'd10, 2'd1, 1'b1, 1'b0, 5'd16, 64'hFFFF7FFF01000000, 64'h00027FFF01000000, 64'hFFFF3FFF00010000, 1'b0, 8'd8},
    '{4'd10, 2'd1, 1'b0, 1'b0, 5'd7,  64'h0080000000000000, 64'h0100000000000000, 64'h0100000000000000, 1'b0, 8'd8},
    '{4'd10, 2'd1, 1'b0, 1'b0, 5'd15, 64'h000000000000FFFF, 64'h000000000000FFFF, 64'h000000000000FFFC, 1'b0, 8'd8},
    // R9 rejected combinations
    '{4'd2,  2'd2, 1'b1, 1'b0, 5'd0, 64'h7FFFFFFF00000001, 64'h0000000100000001, 64'h0, 1'b1, 8'd9},
    '{4'd9,  2'd1, 1'b0, 1'b0, 5'd0, 64'hFF00000000000005, 64'h00FF000000000008, 64'h0, 1'b1, 8'd9},
    '{4'd10, 2'd1, 1'b0, 1'b0, 5'd8, 64'h0003000300030003, 64'h0004000400040004, 64'h0, 1'b1, 8'd9},
    '{4'd0,  2'd3, 1'b0, 1'b0, 5'd0, 64'h0101010101010101, 64'h0101010101010101, 64'h0, 1'b1, 8'd9},
    '{4'd12, 2'd0, 1'b0, 1'b0, 5'd0, 64'h0101010101010101, 64'h0101010101010101, 64'h0, 1'b1, 8'd9},
    '{4'd6,  2'd2, 1'b0, 1'b0, 5'd0, 64'h0000000400000004, 64'h0000000200000002, 64'h0, 1'b1, 8'd9},
    '{4'd10, 2'd0, 1'b0, 1'b0, 5'd0, 64'h0202020202020202, 64'h0303030303030303, 64'h0, 1'b1, 8'd9}
  };

  logic        clk, rst_n, valid_i, signed_i, round_i;
  logic [3:0]  op_i;
  logic [1:0]  size_i;
  logic [4:0]  shift_i;
  logic [63:0] src_a, src_b, result;
  logic        valid_o, illegal;
  int          n_chk, n_fail;
  bit          done;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  simd_int_alu u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .size_i   (size_i),
    .signed_i (signed_i),
    .round_i  (round_i),
    .shift_i  (shift_i),
    .src_a_i  (src_a),
    .src_b_i  (src_b),
    .valid_o  (valid_o),
    .result_o (result),
    .illegal_o(illegal)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; valid_i = 1'b0; op_i = '0; size_i = '0;
    signed_i = 1'b0; round_i = 1'b0; shift_i = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", {63'd0, valid_o}, 64'd0);
    check("R1 reset result", result, 64'd0);
    check("R1 reset illegal", {63'd0, illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v.req, i);
      valid_i = 1'b1; op_i = v.op; size_i = v.sz; signed_i = v.sg;
      round_i = v.rn; shift_i = v.sh; src_a = v.a; src_b = v.b;
      @(negedge clk);
      check({tag, " result"}, result, v.exp);
      check({tag, " illegal"}, {63'd0, illegal}, {63'd0, v.err});
      check("R1 valid follows", {63'd0, valid_o}, 64'd1);
    end

    // R1: hold while idle, inputs ignored
    valid_i = 1'b1; op_i = 4'd0; size_i = 2'd0;
    src_a = 64'h0000000000000011; src_b = 64'h0000000000000022;
    @(negedge clk);
    valid_i = 1'b0; op_i = 4'd12; size_i = 2'd3;
    src_a = 64'hFFFFFFFFFFFFFFFF; src_b = 64'hFFFFFFFFFFFFFFFF;
    @(negedge clk);
    check("R1 idle valid low", {63'd0, valid_o}, 64'd0);
    check("R1 idle result hold", result, 64'h0000000000000033);
    check("R1 idle illegal hold", {63'd0, illegal}, 64'd0);
    @(negedge clk);
    check("R1 idle result still held", result, 64'h0000000000000033);

    // R9 then legal clears the flag
    valid_i = 1'b1; op_i = 4'd15; size_i = 2'd0;
    @(negedge clk);
    check("R9 reserved op flag", {63'd0, illegal}, 64'd1);
    op_i = 4'd1; size_i = 2'd2; src_a = 64'h0000000500000000; src_b = 64'h0000000600000001;
    @(negedge clk);
    check("R2 word borrow wrap", result, 64'hFFFFFFFFFFFFFFFF);
    check("R9 flag cleared", {63'd0, illegal}, 64'd0);
    valid_i = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule